// File: doc/BRIEF.md
# Delayed Read Retry and Expiry Supervisor

This block watches a single delayed read request through its whole life inside a bus bridge. It starts when the request is posted. While the bridge re-issues the read on the target bus, the block counts every retry the target returns. If the programmed number of attempts runs out before any data arrives, the block drops the request and can raise a system error.

Once data has started to arrive, the block stops counting. When the target-bus read has finished, the block waits for the original initiator to come back for the data. During that wait it runs an expiry timer, but the timer only advances while the request sits at the head of the delayed request queue and its data sits at the head of the read data queue. If the initiator does not return in time, the request and its data are dropped, again with an optional system error.

If the initiator takes part of the data and disconnects, the leftover is kept under a second timer. That leftover is dropped at once if read data for another transaction is waiting. A zero programmed limit selects a default that is fixed by parameter.

Top module: `drd_watch`

## Requirements
- R1: A start strobe is accepted only while no request is being supervised, and it clears the attempt count; a start strobe during any other phase has no effect on timing or outputs.
- R2: Each target retry during the retry phase adds one attempt. The cycle after the attempt that brings the count to the effective limit, `discard_o` pulses and the request ends; `serr_o` pulses in that same cycle only if `serr_en_i` is 1.
- R3: An attempt limit of 0 selects 2^ATT_DEF_LOG2 attempts (default 2^24). The limit input is ATT_W bits wide (default 33), so 2^32 can be loaded.
- R4: A data transfer ends the retry phase. Later retries are ignored. An error termination in the retry phase ends supervision with no pulse.
- R5: A completion strobe moves the block into the waiting phase with the timer cleared. The timer advances only in cycles where both head flags are 1.
- R6: In the waiting phase, the cycle after the L-th qualifying cycle, `discard_o` pulses together with `serr_o` when enabled. A timeout limit of 0 selects L = 2^TMO_DEF_LOG2 (default 2^15).
- R7: A repeat hit in the waiting phase stops and clears the timer. If no data is left over, supervision ends with no pulse.
- R8: A repeat hit with `hit_left_i` = 1 enters the leftover phase. There, `other_pend_i` = 1 gives a `discard_o` pulse the next cycle, with `serr_o` = 0. `other_pend_i` has no effect in the waiting phase.
- R9: The leftover timer advances every cycle regardless of the head flags. On expiry after L cycles it pulses `discard_o` only, with `serr_o` = 0.
- R10: Both outputs are 0 during reset, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_start_i | input | 1 | New delayed read request posted |
| retry_i | input | 1 | Target answered an attempt with retry |
| xfer_i | input | 1 | A data transfer completed on the target bus |
| err_term_i | input | 1 | Target-bus read ended by an error termination |
| cmpl_done_i | input | 1 | Target-bus read has finished |
| dtq_head_i | input | 1 | Request is at the head of the delayed request queue |
| rdq_head_i | input | 1 | Its data is at the head of the read data queue |
| hit_i | input | 1 | Initiator repeated the request and was served |
| hit_left_i | input | 1 | With `hit_i`: data remains after the disconnect |
| other_pend_i | input | 1 | Read data of another transaction is waiting |
| att_limit_i | input | ATT_W | Attempt limit, 0 selects the default |
| tmo_limit_i | input | TMO_W | Timer limit in cycles, 0 selects the default |
| serr_en_i | input | 1 | System error reporting enable |
| discard_o | output | 1 | One-cycle pulse: drop request and data |
| serr_o | output | 1 | One-cycle pulse: system error |

## Verification
The bench builds the block with ATT_DEF_LOG2 = 2 and TMO_DEF_LOG2 = 3, so the zero-limit defaults become 4 attempts and 8 cycles. That brings the default paths of R3 and R6 within a few cycles. ATT_W and TMO_W stay at 33 and 16, so a limit of 2^32 can still be loaded and shown to stay quiet over a run of retries. Every pulse is predicted to the exact cycle. This exposes a timer that keeps counting across paused head flags, or one that is not cleared by a repeat hit.

// File: rtl/drd_pkg.sv
package drd_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RETRY,
    PH_FILL,
    PH_WAIT,
    PH_LEFT
  } drd_phase_e;
endpackage

// File: rtl/drd_limit_ctr.sv
module drd_limit_ctr #(
  parameter int unsigned W        = 16,
  parameter int unsigned DEF_LOG2 = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         at_lim_o
);
  localparam logic [W-1:0] DEF_LIM = W'(1) << DEF_LOG2;

  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_eff;

  assign lim_eff  = (limit_i == '0) ? DEF_LIM : limit_i;
  // high when the next increment would reach the limit
  assign at_lim_o = (cnt_q + W'(1)) >= lim_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/drd_ctl.sv
module drd_ctl
  import drd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_start_i,
  input  logic       retry_i,
  input  logic       xfer_i,
  input  logic       err_term_i,
  input  logic       cmpl_done_i,
  input  logic       heads_i,
  input  logic       hit_i,
  input  logic       hit_left_i,
  input  logic       other_pend_i,
  input  logic       serr_en_i,
  input  logic       att_at_lim_i,
  input  logic       tmr_at_lim_i,
  output logic       att_clr_o,
  output logic       att_inc_o,
  output logic       tmr_clr_o,
  output logic       tmr_run_o,
  output drd_phase_e state_o,
  output logic       discard_o,
  output logic       serr_o
);
  drd_phase_e state_q, state_d;
  logic disc_d, serr_d, hit_clr;

  always_comb begin
    state_d   = state_q;
    att_clr_o = 1'b0;
    att_inc_o = 1'b0;
    tmr_run_o = 1'b0;
    hit_clr   = 1'b0;
    disc_d    = 1'b0;
    serr_d    = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (req_start_i) begin
          state_d   = PH_RETRY;
          att_clr_o = 1'b1;
        end
      end
      PH_RETRY: begin
        if (xfer_i) begin
          state_d = cmpl_done_i ? PH_WAIT : PH_FILL;
        end else if (err_term_i) begin
          state_d = PH_IDLE;
        end else if (retry_i) begin
          att_inc_o = 1'b1;
          if (att_at_lim_i) begin
            state_d = PH_IDLE;
            disc_d  = 1'b1;
            serr_d  = serr_en_i;
          end
        end
      end
      PH_FILL: begin
        if (cmpl_done_i) state_d = PH_WAIT;
      end
      PH_WAIT: begin
        if (hit_i) begin
          hit_clr = 1'b1;
          state_d = hit_left_i ? PH_LEFT : PH_IDLE;
        end else if (heads_i) begin
          tmr_run_o = 1'b1;
          if (tmr_at_lim_i) begin
            state_d = PH_IDLE;
            disc_d  = 1'b1;
            serr_d  = serr_en_i;
          end
        end
      end
      PH_LEFT: begin
        if (hit_i) begin
          hit_clr = 1'b1;
          state_d = hit_left_i ? PH_LEFT : PH_IDLE;
        end else if (other_pend_i) begin
          state_d = PH_IDLE;
          disc_d  = 1'b1;
        end else begin
          tmr_run_o = 1'b1;
          if (tmr_at_lim_i) begin
            state_d = PH_IDLE;
            disc_d  = 1'b1;
          end
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  // timer restarts on every phase change and on every repeat hit
  assign tmr_clr_o = (state_d != state_q) || hit_clr;
  assign state_o   = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PH_IDLE;
      discard_o <= 1'b0;
      serr_o    <= 1'b0;
    end else begin
      state_q   <= state_d;
      discard_o <= disc_d;
      serr_o    <= serr_d;
    end
  end
endmodule

// File: rtl/drd_watch.sv
module drd_watch
  import drd_pkg::*;
#(
  parameter int unsigned ATT_W        = 33,
  parameter int unsigned ATT_DEF_LOG2 = 24,
  parameter int unsigned TMO_W        = 16,
  parameter int unsigned TMO_DEF_LOG2 = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_start_i,
  input  logic             retry_i,
  input  logic             xfer_i,
  input  logic             err_term_i,
  input  logic             cmpl_done_i,
  input  logic             dtq_head_i,
  input  logic             rdq_head_i,
  input  logic             hit_i,
  input  logic             hit_left_i,
  input  logic             other_pend_i,
  input  logic [ATT_W-1:0] att_limit_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  input  logic             serr_en_i,
  output logic             discard_o,
  output logic             serr_o
);
  logic       att_clr, att_inc, att_at_lim;
  logic       tmr_clr, tmr_run, tmr_at_lim;
  drd_phase_e state_q;

  drd_limit_ctr #(.W(ATT_W), .DEF_LOG2(ATT_DEF_LOG2)) u_att (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (att_clr),
    .inc_i   (att_inc),
    .limit_i (att_limit_i),
    .at_lim_o(att_at_lim)
  );

  drd_limit_ctr #(.W(TMO_W), .DEF_LOG2(TMO_DEF_LOG2)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmr_clr),
    .inc_i   (tmr_run),
    .limit_i (tmo_limit_i),
    .at_lim_o(tmr_at_lim)
  );

  drd_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_start_i (req_start_i),
    .retry_i     (retry_i),
    .xfer_i      (xfer_i),
    .err_term_i  (err_term_i),
    .cmpl_done_i (cmpl_done_i),
    .heads_i     (dtq_head_i & rdq_head_i),
    .hit_i       (hit_i),
    .hit_left_i  (hit_left_i),
    .other_pend_i(other_pend_i),
    .serr_en_i   (serr_en_i),
    .att_at_lim_i(att_at_lim),
    .tmr_at_lim_i(tmr_at_lim),
    .att_clr_o   (att_clr),
    .att_inc_o   (att_inc),
    .tmr_clr_o   (tmr_clr),
    .tmr_run_o   (tmr_run),
    .state_o     (state_q),
    .discard_o   (discard_o),
    .serr_o      (serr_o)
  );
endmodule

// File: rtl/drd_watch_chk.sv
module drd_watch_chk
  import drd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input drd_phase_e state_i,
  input logic       hit_i,
  input logic       hit_left_i,
  input logic       err_term_i,
  input logic       xfer_i,
  input logic       serr_en_i,
  input logic       discard_o,
  input logic       serr_o
);
  a_r10_disc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |=> !discard_o);
  a_r10_serr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |=> !serr_o);
  a_r2_serr_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |-> $past(serr_en_i));
  a_r2_serr_with_disc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |-> discard_o);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == PH_IDLE) |=> !discard_o);
  a_r4_err_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == PH_RETRY && err_term_i && !xfer_i) |=> (!discard_o && !serr_o));
  a_r7_hit_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == PH_WAIT && hit_i && !hit_left_i) |=> !discard_o);
  a_r9_left_no_serr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == PH_LEFT) |=> !serr_o);
endmodule

bind drd_watch drd_watch_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .state_i   (state_q),
  .hit_i     (hit_i),
  .hit_left_i(hit_left_i),
  .err_term_i(err_term_i),
  .xfer_i    (xfer_i),
  .serr_en_i (serr_en_i),
  .discard_o (discard_o),
  .serr_o    (serr_o)
);

// File: tb/tb_drd_watch.sv
`timescale 1ns/1ps
module tb_drd_watch;
  localparam int unsigned ATT_W = 33, TMO_W = 16, ATT_DEF_LOG2 = 2, TMO_DEF_LOG2 = 3;

  typedef struct {
    int    cyc;
    bit    d;
    bit    s;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, retry = 0, xfer = 0, err = 0, cmpl = 0, dtq = 1, rdq = 1;
  logic hit = 0, hit_left = 0, other = 0, serr_en = 1;
  logic [ATT_W-1:0] att_lim = 3;
  logic [TMO_W-1:0] tmo_lim = 4;
  logic discard, serr;

  int    cyc = 0, checks = 0, errors = 0;
  string cur_tag = "R10";
  exp_t  sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  drd_watch #(.ATT_W(ATT_W), .ATT_DEF_LOG2(ATT_DEF_LOG2),
              .TMO_W(TMO_W), .TMO_DEF_LOG2(TMO_DEF_LOG2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_start_i(start), .retry_i(retry),
    .xfer_i(xfer), .err_term_i(err), .cmpl_done_i(cmpl),
    .dtq_head_i(dtq), .rdq_head_i(rdq), .hit_i(hit), .hit_left_i(hit_left),
    .other_pend_i(other), .att_limit_i(att_lim), .tmo_limit_i(tmo_lim),
    .serr_en_i(serr_en), .discard_o(discard), .serr_o(serr));

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic push(int at, bit d, bit s, string tag);
    exp_t e;
    e.cyc = at; e.d = d; e.s = s; e.tag = tag;
    sb.push_back(e);
    cur_tag = tag;
  endtask

  task automatic quiet(int n, string tag);
    cur_tag = tag;
    tick(n);
    checks++;
  endtask

  // returns the cycle at which the waiting phase was entered
  task automatic enter_wait(output int at);
    start = 1; tick(); start = 0;
    xfer = 1; cmpl = 1; tick(); xfer = 0; cmpl = 0;
    at = cyc;
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (sb.size() > 0 && sb[0].cyc < cyc) begin
        e = sb.pop_front();
        checks++; errors++;
        $display("FAIL %s: no pulse at cycle %0d, actual discard=0 serr=0, expected discard=%0b serr=%0b",
                 e.tag, e.cyc, e.d, e.s);
      end
      if (discard || serr) begin
        checks++;
        if (sb.size() > 0 && sb[0].cyc == cyc) begin
          e = sb.pop_front();
          if (discard !== e.d || serr !== e.s) begin
            errors++;
            $display("FAIL %s: cycle %0d actual discard=%0b serr=%0b, expected discard=%0b serr=%0b",
                     e.tag, cyc, discard, serr, e.d, e.s);
          end
        end else begin
          errors++;
          $display("FAIL %s: unexpected pulse at cycle %0d, actual discard=%0b serr=%0b, expected none",
                   cur_tag, cyc, discard, serr);
        end
      end
    end
  end

  initial begin
    #750000;
    checks++; errors++;
    $display("FAIL watchdog: actual run still going, expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c;
    tick(3);
    checks++;
    if (discard !== 1'b0 || serr !== 1'b0) begin
      errors++;
      $display("FAIL R10: reset outputs actual %0b%0b, expected 00", discard, serr);
    end
    rst_n = 1; tick(2);

    // R2: exhaustion with error reporting on
    start = 1; tick(); start = 0;
    retry = 1; push(cyc + 3, 1, 1, "R2"); tick(3); retry = 0;
    quiet(4, "R2");
    // R2: error reporting off
    serr_en = 0;
    start = 1; tick(); start = 0;
    retry = 1; push(cyc + 3, 1, 0, "R2"); tick(3); retry = 0;
    quiet(4, "R2");
    serr_en = 1;
    // R3: zero attempt limit selects default of 4
    att_lim = 0;
    start = 1; tick(); start = 0;
    retry = 1; push(cyc + 4, 1, 1, "R3"); tick(4); retry = 0;
    quiet(4, "R3");
    att_lim = 3;

    // R4: transfer ends counting; R8: other_pend ignored while waiting; R6 expiry
    start = 1; tick(); start = 0;
    retry = 1; tick(2); retry = 0;
    xfer = 1; tick(); xfer = 0;
    retry = 1; quiet(5, "R4"); retry = 0;
    other = 1; cmpl = 1; push(cyc + 1 + 4, 1, 1, "R6"); tick(); cmpl = 0;
    tick(6); other = 0;

    // R5: timer pauses while either head flag is low
    start = 1; tick(); start = 0;
    rdq = 0; xfer = 1; cmpl = 1; tick(); xfer = 0; cmpl = 0;
    cur_tag = "R5"; tick(3);
    dtq = 0; rdq = 1; tick(3);
    dtq = 1; push(cyc + 4, 1, 1, "R5"); tick(6);

    // R7: hit with nothing left clears timer and ends silently
    enter_wait(c); tick(2);
    hit = 1; tick(); hit = 0;
    quiet(10, "R7");

    // R7 + R9: hit with leftover restarts the timer; leftover timer ignores heads
    enter_wait(c); tick(2);
    hit = 1; hit_left = 1; c = cyc; tick(); hit = 0; hit_left = 0;
    dtq = 0; rdq = 0;
    push(c + 1 + 4, 1, 0, "R9"); tick(7);
    dtq = 1; rdq = 1;

    // R8: other data pending drops the leftover at once, without SERR
    enter_wait(c);
    hit = 1; hit_left = 1; tick(); hit = 0; hit_left = 0;
    tick();
    other = 1; push(cyc + 1, 1, 0, "R8"); tick(); other = 0;
    quiet(6, "R8");

    // R6: zero timeout limit selects default of 8
    tmo_lim = 0;
    enter_wait(c); push(c + 8, 1, 1, "R6"); tick(10);
    tmo_lim = 4;

    // R4: error termination is silent; retries while idle are ignored
    start = 1; tick(); start = 0;
    retry = 1; tick(2); retry = 0;
    err = 1; tick(); err = 0;
    quiet(4, "R4");
    retry = 1; quiet(4, "R4"); retry = 0;
    // R1: new request restarts the attempt count
    start = 1; tick(); start = 0;
    retry = 1; push(cyc + 3, 1, 1, "R1"); tick(3); retry = 0;
    tick(2);

    // R1: start during the waiting phase is ignored
    enter_wait(c); push(c + 4, 1, 1, "R1"); tick(1);
    start = 1; tick(); start = 0; tick(4);

    // R3: a limit of 2^32 does not trip over a run of retries
    att_lim = 33'h1_0000_0000;
    start = 1; tick(); start = 0;
    retry = 1; quiet(20, "R3"); retry = 0;
    err = 1; tick(); err = 0;
    quiet(4, "R3");

    tick(10);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL %s: actual %0d pulses outstanding, expected 0", sb[0].tag, sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule